// File: doc/BRIEF.md
# DDR2 Command Spacing Monitor

This block watches a decoded DDR2 command stream, one command per controller clock, with the bank address of each command. It raises a flag whenever a command arrives sooner after an earlier one than a device timing rule allows. It checks seven rules:

- activate-to-activate spacing across banks;
- the rolling window that limits how many activates may fall in a span of time;
- column-to-column spacing;
- write recovery before precharge;
- write-to-read turnaround;
- read-to-precharge;
- refresh cycle time.

Each rule owns one bit of a pulse vector and one bit of a sticky vector. A combined error pulse marks any offending command.

Each limit is given in picoseconds and turned into a clock count when the design is elaborated, using the clock period parameter. A single parameter selects either the narrow-page or the wide-page device organisation. This choice changes the activate spacing limit and the activate window length. The monitor only observes. It never blocks a command, and it records every command as a new reference point, including one that broke a rule.

Top module: `ddr2_cmd_timing_chk`

## Requirements
- R1: Command code `cmd` is 0 idle, 1 activate, 2 read, 3 write, 4 precharge of bank `bank`, 5 precharge of all banks, 6 refresh; code 7 acts as idle. While reset is held and right after its release, `viol`, `viol_sticky` and `err` are all zero.
- R2: An activate to a bank other than the last activated bank, fewer than tRRD clocks after that activate, sets rule bit 0. An activate to the same bank is not checked by this rule.
- R3: An activate issued while the fourth most recent earlier activate is fewer than tFAW clocks old sets rule bit 1.
- R4: A read or write fewer than tCCD = 2 clocks after the previous read or write sets rule bit 2.
- R5: A precharge to a bank written fewer than tWR clocks earlier sets rule bit 3. A precharge of all banks sets it if any bank was written that recently.
- R6: A read fewer than tWTR clocks after the most recent write to any bank sets rule bit 4.
- R7: A precharge to a bank read fewer than tRTP clocks earlier sets rule bit 5. A precharge of all banks sets it if any bank was read that recently.
- R8: An activate or refresh fewer than tRFC clocks after the last refresh sets rule bit 6.
- R9: Each limit in clocks is the nanosecond value divided by the clock period, rounded up. With the default 3.75 ns period this gives:
  - tRRD: 2 (narrow page), 3 (wide page);
  - tFAW: 10 (narrow page), 14 (wide page);
  - tWR: 4;
  - tWTR: 2;
  - tRTP: 2;
  - tRFC: 34.

  A spacing exactly equal to the limit is legal.
- R10: The rule bit in `viol` is high for exactly the one clock after the offending command. `err` is high in that same clock whenever any bit of `viol` is high.
- R11: A bit of `viol_sticky` is set together with its pulse and stays set until `clr` is sampled high. If a new violation and `clr` arrive in the same clock, the new violation's bit stays set.
- R12: A command that breaks a rule still becomes the reference point for later checks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Decoded command code (see R1) |
| bank | input | BANK_W | Bank address of the command |
| clr | input | 1 | Synchronous clear of the sticky flags |
| viol | output | 7 | Per-rule violation pulse, bit order RRD, FAW, CCD, WR, WTR, RTP, RFC |
| viol_sticky | output | 7 | Per-rule sticky violation flags |
| err | output | 1 | Pulse when any rule is broken |

## Verification
The bench places commands exactly at each limit and one clock short of it. A design that is off by one in its rounding or its age counting either flags legal traffic or misses the early command.

It also covers the less obvious cases:
- two back-to-back activates to one bank, which a design that ignores the bank comparison would flag;
- a fifth activate measured against an activate that was itself a violation, which a design that skips recording offenders would let through;
- a precharge of all banks that must see a young write on some other bank.

A clear that lands together with a new violation checks that the set wins. A second instance built for the wide-page organisation must flag spacings that the narrow-page instance accepts.

// File: rtl/ddr2_chk_pkg.sv
package ddr2_chk_pkg;

  localparam logic [2:0] CMD_NOP  = 3'd0;
  localparam logic [2:0] CMD_ACT  = 3'd1;
  localparam logic [2:0] CMD_RD   = 3'd2;
  localparam logic [2:0] CMD_WR   = 3'd3;
  localparam logic [2:0] CMD_PRE  = 3'd4;
  localparam logic [2:0] CMD_PREA = 3'd5;
  localparam logic [2:0] CMD_REF  = 3'd6;

  localparam int NRULE    = 7;
  localparam int RULE_RRD = 0;
  localparam int RULE_FAW = 1;
  localparam int RULE_CCD = 2;
  localparam int RULE_WR  = 3;
  localparam int RULE_WTR = 4;
  localparam int RULE_RTP = 5;
  localparam int RULE_RFC = 6;

  // R9: round a picosecond limit up to whole clocks
  function automatic int ps_to_clk(input int ps, input int clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr2_age_tracker.sv
module ddr2_age_tracker #(
  parameter int AGE_W   = 6,
  parameter int AGE_MAX = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  output logic [AGE_W-1:0] age
);

  localparam logic [AGE_W-1:0] SAT = AGE_W'(AGE_MAX);

  logic [AGE_W-1:0] age_d;

  // age counts clocks since the last hit; saturated means "long ago"
  always_comb begin
    if (hit)             age_d = AGE_W'(1);
    else if (age == SAT) age_d = SAT;
    else                 age_d = age + AGE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= SAT;
    else        age <= age_d;
  end

  assert_age_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    age != '0);

endmodule

// File: rtl/ddr2_bank_ages.sv
module ddr2_bank_ages #(
  parameter int BANK_W  = 3,
  parameter int AGE_W   = 6,
  parameter int AGE_MAX = 34
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              hit,
  input  logic [BANK_W-1:0]                 bank,
  output logic [(1<<BANK_W)-1:0][AGE_W-1:0] ages
);

  localparam int BANKS = 1 << BANK_W;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    ddr2_age_tracker #(.AGE_W(AGE_W), .AGE_MAX(AGE_MAX)) u_age (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit && (bank == BANK_W'(b))),
      .age   (ages[b])
    );
  end

endmodule

// File: rtl/ddr2_faw_window.sv
module ddr2_faw_window #(
  parameter int DEPTH   = 4,
  parameter int AGE_W   = 6,
  parameter int AGE_MAX = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  output logic [AGE_W-1:0] oldest
);

  localparam logic [AGE_W-1:0] SAT = AGE_W'(AGE_MAX);

  logic [DEPTH-1:0][AGE_W-1:0] slot_q, slot_d;

  function automatic logic [AGE_W-1:0] sat_inc(input logic [AGE_W-1:0] v);
    return (v == SAT) ? SAT : v + AGE_W'(1);
  endfunction

  // slot 0 holds the newest activate; an activate shifts all slots down
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_head
      always_comb slot_d[i] = act ? AGE_W'(1) : sat_inc(slot_q[i]);
    end else begin : g_tail
      always_comb slot_d[i] = act ? sat_inc(slot_q[i-1]) : sat_inc(slot_q[i]);
      assert_faw_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q[i-1] <= slot_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= {DEPTH{SAT}};
    else        slot_q <= slot_d;
  end

  assign oldest = slot_q[DEPTH-1];

endmodule

// File: rtl/ddr2_cmd_timing_chk.sv
module ddr2_cmd_timing_chk
  import ddr2_chk_pkg::*;
#(
  parameter int CLK_PS        = 3750,
  parameter bit WIDE_PAGE     = 1'b0,
  parameter int BANK_W        = 3,
  parameter int FAW_ACTS      = 4,
  parameter int CCD_CLK       = 2,
  parameter int RRD_NARROW_PS = 7500,
  parameter int RRD_WIDE_PS   = 10000,
  parameter int FAW_NARROW_PS = 37500,
  parameter int FAW_WIDE_PS   = 50000,
  parameter int WR_PS         = 15000,
  parameter int WTR_PS        = 7500,
  parameter int RTP_PS        = 7500,
  parameter int RFC_PS        = 127500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic              clr,
  output logic [6:0]        viol,
  output logic [6:0]        viol_sticky,
  output logic              err
);

  localparam int BANKS   = 1 << BANK_W;
  localparam int N_RRD   = ps_to_clk(WIDE_PAGE ? RRD_WIDE_PS : RRD_NARROW_PS, CLK_PS);
  localparam int N_FAW   = ps_to_clk(WIDE_PAGE ? FAW_WIDE_PS : FAW_NARROW_PS, CLK_PS);
  localparam int N_WR    = ps_to_clk(WR_PS, CLK_PS);
  localparam int N_WTR   = ps_to_clk(WTR_PS, CLK_PS);
  localparam int N_RTP   = ps_to_clk(RTP_PS, CLK_PS);
  localparam int N_RFC   = ps_to_clk(RFC_PS, CLK_PS);
  localparam int AGE_MAX = imax(imax(imax(N_RRD, N_FAW), imax(N_WR, N_WTR)),
                                imax(imax(N_RTP, N_RFC), CCD_CLK));
  localparam int AGE_W   = $clog2(AGE_MAX + 1);

  localparam logic [AGE_W-1:0] LIM_RRD = AGE_W'(N_RRD);
  localparam logic [AGE_W-1:0] LIM_FAW = AGE_W'(N_FAW);
  localparam logic [AGE_W-1:0] LIM_CCD = AGE_W'(CCD_CLK);
  localparam logic [AGE_W-1:0] LIM_WR  = AGE_W'(N_WR);
  localparam logic [AGE_W-1:0] LIM_WTR = AGE_W'(N_WTR);
  localparam logic [AGE_W-1:0] LIM_RTP = AGE_W'(N_RTP);
  localparam logic [AGE_W-1:0] LIM_RFC = AGE_W'(N_RFC);

  // R1: command decode
  logic is_act, is_rd, is_wr, is_pre, is_prea, is_ref, is_col;
  always_comb begin
    is_act  = (cmd == CMD_ACT);
    is_rd   = (cmd == CMD_RD);
    is_wr   = (cmd == CMD_WR);
    is_pre  = (cmd == CMD_PRE);
    is_prea = (cmd == CMD_PREA);
    is_ref  = (cmd == CMD_REF);
    is_col  = is_rd | is_wr;
  end

  // R12: every command restarts its trackers, legal or not
  logic [AGE_W-1:0] act_age, col_age, wr_any_age, ref_age, faw_oldest;
  logic [BANKS-1:0][AGE_W-1:0] wr_ages, rd_ages;

  ddr2_age_tracker #(.AGE_W(AGE_W), .AGE_MAX(AGE_MAX)) u_act_age (
    .clk(clk), .rst_n(rst_n), .hit(is_act), .age(act_age));
  ddr2_age_tracker #(.AGE_W(AGE_W), .AGE_MAX(AGE_MAX)) u_col_age (
    .clk(clk), .rst_n(rst_n), .hit(is_col), .age(col_age));
  ddr2_age_tracker #(.AGE_W(AGE_W), .AGE_MAX(AGE_MAX)) u_wr_age (
    .clk(clk), .rst_n(rst_n), .hit(is_wr), .age(wr_any_age));
  ddr2_age_tracker #(.AGE_W(AGE_W), .AGE_MAX(AGE_MAX)) u_ref_age (
    .clk(clk), .rst_n(rst_n), .hit(is_ref), .age(ref_age));

  ddr2_bank_ages #(.BANK_W(BANK_W), .AGE_W(AGE_W), .AGE_MAX(AGE_MAX)) u_wr_banks (
    .clk(clk), .rst_n(rst_n), .hit(is_wr), .bank(bank), .ages(wr_ages));
  ddr2_bank_ages #(.BANK_W(BANK_W), .AGE_W(AGE_W), .AGE_MAX(AGE_MAX)) u_rd_banks (
    .clk(clk), .rst_n(rst_n), .hit(is_rd), .bank(bank), .ages(rd_ages));

  ddr2_faw_window #(.DEPTH(FAW_ACTS), .AGE_W(AGE_W), .AGE_MAX(AGE_MAX)) u_faw (
    .clk(clk), .rst_n(rst_n), .act(is_act), .oldest(faw_oldest));

  // bank of the most recent activate (R2)
  logic [BANK_W-1:0] last_bank_q, last_bank_d;
  logic              last_bank_en;
  always_comb begin
    last_bank_en = is_act;
    last_bank_d  = bank;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            last_bank_q <= '0;
    else if (last_bank_en) last_bank_q <= last_bank_d;
  end

  // any-bank recency for precharge-all (R5, R7)
  logic wr_young_any, rd_young_any;
  always_comb begin
    wr_young_any = 1'b0;
    rd_young_any = 1'b0;
    for (int b = 0; b < BANKS; b++) begin
      if (wr_ages[b] < LIM_WR)  wr_young_any = 1'b1;
      if (rd_ages[b] < LIM_RTP) rd_young_any = 1'b1;
    end
  end

  logic [NRULE-1:0] rule_hit;
  always_comb begin
    rule_hit           = '0;
    rule_hit[RULE_RRD] = is_act && (bank != last_bank_q) && (act_age < LIM_RRD);
    rule_hit[RULE_FAW] = is_act && (faw_oldest < LIM_FAW);
    rule_hit[RULE_CCD] = is_col && (col_age < LIM_CCD);
    rule_hit[RULE_WR]  = (is_pre && (wr_ages[bank] < LIM_WR)) || (is_prea && wr_young_any);
    rule_hit[RULE_WTR] = is_rd && (wr_any_age < LIM_WTR);
    rule_hit[RULE_RTP] = (is_pre && (rd_ages[bank] < LIM_RTP)) || (is_prea && rd_young_any);
    rule_hit[RULE_RFC] = (is_act || is_ref) && (ref_age < LIM_RFC);
  end

  // R10, R11: flag registers
  logic [NRULE-1:0] sticky_d;
  logic             err_d;
  always_comb begin
    sticky_d = (clr ? '0 : viol_sticky) | rule_hit;
    err_d    = |rule_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol        <= '0;
      viol_sticky <= '0;
      err         <= 1'b0;
    end else begin
      viol        <= rule_hit;
      viol_sticky <= sticky_d;
      err         <= err_d;
    end
  end

  assert_pulse_in_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (viol & ~viol_sticky) == '0);
  assert_sticky_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((viol_sticky & $past(viol_sticky)) == $past(viol_sticky)));
  assert_err_any_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err == (|viol));
  assert_rrd_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_RRD] |-> $past(cmd) == CMD_ACT);
  assert_faw_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_FAW] |-> $past(cmd) == CMD_ACT);
  assert_ccd_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_CCD] |-> ($past(cmd) == CMD_RD || $past(cmd) == CMD_WR));
  assert_wr_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_WR] |-> ($past(cmd) == CMD_PRE || $past(cmd) == CMD_PREA));
  assert_wtr_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_WTR] |-> $past(cmd) == CMD_RD);
  assert_rtp_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_RTP] |-> ($past(cmd) == CMD_PRE || $past(cmd) == CMD_PREA));
  assert_rfc_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_RFC] |-> ($past(cmd) == CMD_ACT || $past(cmd) == CMD_REF));

endmodule

// File: tb/tb_ddr2_cmd_timing_chk.sv
module tb_ddr2_cmd_timing_chk;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cmd;
  logic [2:0] bank;
  logic       clr;
  logic [6:0] viol, viol_sticky, viol_w, sticky_w;
  logic       err, err_w;
  int         nvec = 0;
  int         nfail = 0;

  always #4 clk = ~clk;  // 125 MHz

  ddr2_cmd_timing_chk dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .clr(clr),
    .viol(viol), .viol_sticky(viol_sticky), .err(err));

  ddr2_cmd_timing_chk #(.WIDE_PAGE(1'b1)) dut_w (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .clr(clr),
    .viol(viol_w), .viol_sticky(sticky_w), .err(err_w));

  // {cmd, bank, expected viol}; narrow page, limits per R9
  localparam int NV = 43;
  localparam logic [12:0] VEC [NV] = '{
    {3'd1, 3'd0, 7'h00},  // c0  first activate
    {3'd1, 3'd1, 7'h01},  // c1  R2 other bank 1 clk later
    {3'd1, 3'd1, 7'h00},  // c2  R2 same bank exempt
    {3'd1, 3'd2, 7'h01},  // c3  R2
    {3'd0, 3'd0, 7'h00},
    {3'd1, 3'd3, 7'h02},  // c5  R3 fifth act, oldest age 5; R2 spacing 2 legal
    {3'd0, 3'd0, 7'h00},
    {3'd0, 3'd0, 7'h00},
    {3'd0, 3'd0, 7'h00},
    {3'd0, 3'd0, 7'h00},
    {3'd0, 3'd0, 7'h00},
    {3'd1, 3'd4, 7'h00},  // c11 R3 oldest age exactly 10, R12 c5 counted
    {3'd3, 3'd0, 7'h00},  // c12 write
    {3'd2, 3'd0, 7'h14},  // c13 R4 and R6
    {3'd0, 3'd0, 7'h00},
    {3'd3, 3'd1, 7'h00},  // c15 R4 spacing 2 legal
    {3'd0, 3'd0, 7'h00},
    {3'd2, 3'd2, 7'h00},  // c17 R6 spacing 2 legal
    {3'd0, 3'd0, 7'h00},
    {3'd3, 3'd3, 7'h00},
    {3'd3, 3'd3, 7'h04},  // c20 R4 write after write
    {3'd4, 3'd3, 7'h08},  // c21 R5
    {3'd0, 3'd0, 7'h00},
    {3'd4, 3'd1, 7'h00},
    {3'd4, 3'd2, 7'h00},
    {3'd2, 3'd6, 7'h00},
    {3'd4, 3'd6, 7'h20},  // c26 R7
    {3'd0, 3'd0, 7'h00},
    {3'd2, 3'd7, 7'h00},
    {3'd0, 3'd0, 7'h00},
    {3'd4, 3'd7, 7'h00},  // c30 R7 spacing 2 legal
    {3'd3, 3'd5, 7'h00},
    {3'd0, 3'd0, 7'h00},
    {3'd0, 3'd0, 7'h00},
    {3'd0, 3'd0, 7'h00},
    {3'd4, 3'd5, 7'h00},  // c35 R5 spacing 4 legal
    {3'd3, 3'd4, 7'h00},
    {3'd0, 3'd0, 7'h00},
    {3'd5, 3'd0, 7'h08},  // c38 R5 precharge-all, bank 4 young
    {3'd6, 3'd0, 7'h00},
    {3'd6, 3'd0, 7'h40},  // c40 R8 refresh after refresh
    {3'd1, 3'd0, 7'h40},  // c41 R8 activate after refresh
    {3'd1, 3'd1, 7'h41}   // c42 R12 offending c41 is the reference for R2
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic [2:0] b, input logic cl);
    cmd = c; bank = b; clr = cl;
    @(negedge clk);
    cmd = 3'd0; bank = 3'd0; clr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(3'd0, 3'd0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd = 3'd0; bank = 3'd0; clr = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", {err, viol}, 8'h00);
    check("R1 reset sticky", {1'b0, viol_sticky}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {err, viol}, 8'h00);

    // rule table, R2..R8, R10, R12
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][12:10], VEC[i][9:7], 1'b0);
      check($sformatf("R10 vector %0d", i), {err, viol}, {|VEC[i][6:0], VEC[i][6:0]});
    end

    check("R11 all sticky", {1'b0, viol_sticky}, 8'h7F);
    step(3'd0, 3'd0, 1'b1);
    check("R11 clear", {1'b0, viol_sticky}, 8'h00);

    // R11 set wins over clear; refresh 3+ clocks after the last one
    step(3'd6, 3'd0, 1'b1);
    check("R11 set wins", {1'b0, viol_sticky}, 8'h40);
    check("R8 early refresh", {err, viol}, 8'hC0);

    // R8 boundary: 33 clocks early, 34 legal
    idle(32);
    step(3'd6, 3'd0, 1'b0);
    check("R8 spacing 33", {err, viol}, 8'hC0);
    idle(33);
    step(3'd1, 3'd0, 1'b0);
    check("R8 spacing 34", {err, viol}, 8'h00);

    // R9 wide page: tRRD 3, tFAW 14
    idle(15);
    step(3'd1, 3'd0, 1'b0);
    idle(1);
    step(3'd1, 3'd1, 1'b0);
    check("R9 narrow rrd 2", {err, viol}, 8'h00);
    check("R9 wide rrd 2", {err_w, viol_w}, 8'h81);
    idle(2);
    step(3'd1, 3'd2, 1'b0);
    check("R9 wide rrd 3", {err_w, viol_w}, 8'h00);
    idle(2);
    step(3'd1, 3'd3, 1'b0);
    idle(2);
    step(3'd1, 3'd4, 1'b0);
    check("R9 narrow faw 11", {err, viol}, 8'h00);
    check("R9 wide faw 11", {err_w, viol_w}, 8'h82);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule